// File: doc/BRIEF.md
# Converter Fault Mode Manager

This block decides when a switching converter must stop switching and when it may resume. It collects six fault sources: junction over-temperature, a low level on the external fault pin (thermistor over-temperature), a high level on the same pin (output over-voltage), an integrated overload, a run of short-circuit terminations, and an over-voltage on the controller supply. While any of them is active, the block holds the converter in fault mode. In that mode it removes the switching enable and raises a low-power indicator for the bias circuitry.

Each source leaves fault mode by its own rule. The supply over-voltage debounce, the overload integrator and the auto-recovery interval are saturating counters, and their lengths are parameters. Junction over-temperature clears when the temperature-recovered flag is seen. Pin over-temperature needs the recovery interval to have run out and also the pin to be back above its recovery level. Output over-voltage, short-circuit and overload need only the recovery interval. Supply over-voltage stays latched until a controller reset. A cause register records which source put the block into fault mode.

Top module: `fault_mode_mgr`

## Requirements
- R1: After `rst_n` is released, and in the cycle after a `ctrl_reset` cycle, `sw_en` is 1, `low_pwr` is 0 and `fault_cause` is 0.
- R2: The overload integrator counts the clock cycles in which `ilim_term` is 1 outside fault mode, and holds its count in cycles without it. After the edge that brings the count to `OVLD_LIMIT`, fault mode starts at the following edge. No overload fault results while the count is below `OVLD_LIMIT`.
- R3: The overload count returns to zero when the auto-recovery interval ends, so a later overload again needs `OVLD_LIMIT` counted cycles.
- R4: The supply over-voltage fault is raised one edge after `vcc_ovp_cmp` has been 1 at `VOVP_FILT` consecutive edges. A single cycle with the comparator at 0 restarts that run.
- R5: A supply over-voltage fault keeps the block in fault mode, however long it lasts, until `ctrl_reset`.
- R6: Output over-voltage, short-circuit and overload faults end at the edge `AR_LEN + 1` cycles after the entry edge. An output over-voltage request still held at 1 keeps the block in fault mode until the request drops.
- R7: A pin over-temperature fault ends only once the auto-recovery interval has run out and `otp_rec` is 1 while `otp_req` is 0.
- R8: A junction over-temperature fault ends at the edge where `tsd_clear` is 1 and `tsd_req` is 0, and does not wait for auto-recovery.
- R9: `ctrl_reset` clears every fault, the latched supply over-voltage included, and all timers.
- R10: In fault mode `sw_en` is 0 and `low_pwr` is 1. Outside it they are 1 and 0.
- R11: `fault_cause` is loaded only on entry into fault mode and holds while fault mode lasts. The codes are: 1 supply over-voltage, 2 junction over-temperature, 3 pin over-temperature, 4 output over-voltage, 5 short-circuit, 6 overload. When several sources arrive at the entry edge, the lowest code wins.
- R12: The auto-recovery interval starts at entry and is not restarted by faults that arrive while fault mode lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset | input | 1 | Synchronous controller reset (supply or undervoltage pin below reset level) |
| tsd_req | input | 1 | Junction over-temperature request |
| tsd_clear | input | 1 | Junction temperature has fallen by the hysteresis |
| otp_req | input | 1 | Fault pin below over-temperature level, already filtered |
| otp_rec | input | 1 | Fault pin above recovery level |
| ovp_req | input | 1 | Fault pin above over-voltage level, already filtered |
| scp_req | input | 1 | Short-circuit termination run reached its count |
| ilim_term | input | 1 | Current limit ended the drive pulse this cycle |
| vcc_ovp_cmp | input | 1 | Raw supply over-voltage comparator |
| sw_en | output | 1 | Switching allowed |
| low_pwr | output | 1 | Low-current fault-mode indicator |
| fault_cause | output | 3 | Code of the source that caused the latest entry |

## Verification
The assertions assume that `rst_n` and `ctrl_reset` are the only ways to clear the block. They also assume that the recovery flags are qualified by the source logic. For example, `tsd_clear` is only meaningful with `tsd_req` low, which the block enforces but the stimulus also mostly respects. The random stimulus keeps single-cycle fault requests rare. This lets full recovery intervals complete between entries. Long comparator bursts are rare enough that the latched supply fault is reached only now and then, and a random `ctrl_reset` soon clears it. `ilim_term` is frequent but is ignored during fault mode, as switching is off there.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int NSRC     = 6;
    localparam int SRC_VOVP = 0;
    localparam int SRC_TSD  = 1;
    localparam int SRC_OTP  = 2;
    localparam int SRC_OVP  = 3;
    localparam int SRC_SCP  = 4;
    localparam int SRC_OVLD = 5;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_VOVP = 3'd1,
        CAUSE_TSD  = 3'd2,
        CAUSE_OTP  = 3'd3,
        CAUSE_OVP  = 3'd4,
        CAUSE_SCP  = 3'd5,
        CAUSE_OVLD = 3'd6
    } cause_e;

    typedef struct packed {
        logic [NSRC-1:0] act;
        cause_e          cause;
    } core_st_t;

endpackage

// File: rtl/fmm_sat_cnt.sv
module fmm_sat_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != TOP)) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = (st_q.cnt == TOP);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);

    // R2
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(st_q.cnt));

endmodule

// File: rtl/fmm_fault_core.sv
module fmm_fault_core
    import fmm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_reset,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr_ok,
    output logic [NSRC-1:0] act,
    output cause_e          cause
);
    core_st_t st_d, st_q;
    logic     idle;

    assign idle = (st_q.act == '0);

    always_comb begin
        st_d = st_q;
        if (ctrl_reset) begin
            st_d.act   = '0;
            st_d.cause = CAUSE_NONE;
        end else begin
            st_d.act = req | (st_q.act & ~clr_ok);
            if (idle && (req != '0)) begin
                for (int i = NSRC - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        st_d.cause = cause_e'(3'(i + 1));
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act   <= '0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign act   = st_q.act;
    assign cause = st_q.cause;

    // R11
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !ctrl_reset) |=> $stable(st_q.cause));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |=> (st_q.act == '0) && (st_q.cause == CAUSE_NONE));

    // R11
    cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (st_q.cause != CAUSE_NONE));

endmodule

// File: rtl/fault_mode_mgr.sv
module fault_mode_mgr
    import fmm_pkg::*;
#(
    parameter int OVLD_LIMIT = 30000,
    parameter int VOVP_FILT  = 3000,
    parameter int AR_LEN     = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_reset,
    input  logic       tsd_req,
    input  logic       tsd_clear,
    input  logic       otp_req,
    input  logic       otp_rec,
    input  logic       ovp_req,
    input  logic       scp_req,
    input  logic       ilim_term,
    input  logic       vcc_ovp_cmp,
    output logic       sw_en,
    output logic       low_pwr,
    output logic [2:0] fault_cause
);
    logic [NSRC-1:0] act;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] clr_ok;
    cause_e          cause;
    logic            in_fault;
    logic            ar_done;
    logic            ovld_hit;
    logic            vovp_hit;

    assign in_fault = (act != '0);

    fmm_sat_cnt #(.LIMIT(OVLD_LIMIT)) u_ovld (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_reset || (in_fault && ar_done)),
        .inc   (ilim_term && !in_fault),
        .hit   (ovld_hit)
    );

    fmm_sat_cnt #(.LIMIT(VOVP_FILT)) u_vovp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_reset || !vcc_ovp_cmp),
        .inc   (vcc_ovp_cmp),
        .hit   (vovp_hit)
    );

    fmm_sat_cnt #(.LIMIT(AR_LEN)) u_arec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_reset || !in_fault),
        .inc   (1'b1),
        .hit   (ar_done)
    );

    always_comb begin
        req           = '0;
        req[SRC_VOVP] = vovp_hit;
        req[SRC_TSD]  = tsd_req;
        req[SRC_OTP]  = otp_req;
        req[SRC_OVP]  = ovp_req;
        req[SRC_SCP]  = scp_req;
        req[SRC_OVLD] = ovld_hit && !in_fault;

        clr_ok           = '0;
        clr_ok[SRC_VOVP] = 1'b0;
        clr_ok[SRC_TSD]  = tsd_clear && !tsd_req;
        clr_ok[SRC_OTP]  = ar_done && otp_rec && !otp_req;
        clr_ok[SRC_OVP]  = ar_done && !ovp_req;
        clr_ok[SRC_SCP]  = ar_done;
        clr_ok[SRC_OVLD] = ar_done;
    end

    fmm_fault_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_reset (ctrl_reset),
        .req        (req),
        .clr_ok     (clr_ok),
        .act        (act),
        .cause      (cause)
    );

    assign sw_en       = !in_fault;
    assign low_pwr     = in_fault;
    assign fault_cause = cause;

    // R5
    vovp_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act[SRC_VOVP] && !ctrl_reset) |=> act[SRC_VOVP]);

    // R12
    ar_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fault && ar_done && !ctrl_reset) |=> ar_done);

    // R6
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_fault) |-> ($past(ar_done) || $past(tsd_clear) || $past(ctrl_reset)));

    // R4
    vovp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vovp_hit |-> $past(vcc_ovp_cmp));

    // R10
    no_switch_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fault && !ctrl_reset && !ar_done && !tsd_clear) |=> !sw_en && low_pwr);

endmodule

// File: tb/sim_fault_mode_mgr.sv
module sim_fault_mode_mgr;
    localparam int OV = 20;
    localparam int VF = 10;
    localparam int AR = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_reset = 0, tsd_req = 0, tsd_clear = 0, otp_req = 0, otp_rec = 0;
    logic ovp_req = 0, scp_req = 0, ilim_term = 0, vcc_ovp_cmp = 0;
    logic sw_en, low_pwr;
    logic [2:0] fault_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    fault_mode_mgr #(.OVLD_LIMIT(OV), .VOVP_FILT(VF), .AR_LEN(AR)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset),
        .tsd_req(tsd_req), .tsd_clear(tsd_clear), .otp_req(otp_req),
        .otp_rec(otp_rec), .ovp_req(ovp_req), .scp_req(scp_req),
        .ilim_term(ilim_term), .vcc_ovp_cmp(vcc_ovp_cmp),
        .sw_en(sw_en), .low_pwr(low_pwr), .fault_cause(fault_cause)
    );

    // reference model built from the requirements
    logic [5:0] m_act = '0;
    int m_cause = 0, m_ar = 0, m_ov = 0, m_v = 0;

    function automatic int first_code(input logic [5:0] r);
        for (int i = 0; i < 6; i++) if (r[i]) return i + 1;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || ctrl_reset) begin
            m_act <= '0; m_cause <= 0; m_ar <= 0; m_ov <= 0; m_v <= 0;
        end else begin
            logic inf, ard;
            logic [5:0] r, c;
            inf = (m_act != 0);
            ard = (m_ar == AR);
            r = {(m_ov == OV) && !inf, scp_req, ovp_req, otp_req, tsd_req, (m_v == VF)};
            c = {ard, ard, ard && !ovp_req, ard && otp_rec && !otp_req, tsd_clear && !tsd_req, 1'b0};
            m_act <= r | (m_act & ~c);
            if (!inf && r != 0) m_cause <= first_code(r);
            m_ar <= inf ? ((m_ar < AR) ? m_ar + 1 : AR) : 0;
            if (inf && ard) m_ov <= 0;
            else if (ilim_term && !inf && m_ov < OV) m_ov <= m_ov + 1;
            m_v <= !vcc_ovp_cmp ? 0 : ((m_v < VF) ? m_v + 1 : VF);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(sw_en == (m_act == 0) && low_pwr == (m_act != 0), "R10 sw_en", sw_en, (m_act == 0));
            chk(fault_cause == m_cause[2:0], "R11 cause", fault_cause, m_cause);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        ctrl_reset = 1; step(1); ctrl_reset = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk(sw_en == 1 && low_pwr == 0, "R1 enable", sw_en, 1);
        chk(fault_cause == 0, "R1 cause", fault_cause, 0);
        cmp_en = 1;

        // R2 integrating overload: 12 + hold + 7 stays enabled
        ilim_term = 1; step(12);
        ilim_term = 0; step(8);
        chk(sw_en == 1, "R2 hold", sw_en, 1);
        ilim_term = 1; step(7);
        chk(sw_en == 1, "R2 below limit", sw_en, 1);
        step(1);
        chk(sw_en == 1, "R2 at limit", sw_en, 1);
        ilim_term = 0; step(1);
        chk(sw_en == 0 && low_pwr == 1, "R10 overload entry", sw_en, 0);
        chk(fault_cause == 6, "R11 overload code", fault_cause, 6);
        // R6 recovery after AR_LEN + 1 cycles
        step(AR);
        chk(sw_en == 0, "R6 before expiry", sw_en, 0);
        step(1);
        chk(sw_en == 1, "R6 after expiry", sw_en, 1);
        // R3 count restarted
        ilim_term = 1; step(OV - 1);
        ilim_term = 0; step(2);
        chk(sw_en == 1, "R3 count cleared", sw_en, 1);
        do_reset();
        chk(sw_en == 1 && fault_cause == 0, "R1 after ctrl_reset", fault_cause, 0);

        // R4 supply over-voltage debounce
        vcc_ovp_cmp = 1; step(VF - 1);
        vcc_ovp_cmp = 0; step(1);
        vcc_ovp_cmp = 1; step(VF - 1);
        vcc_ovp_cmp = 0; step(1);
        chk(sw_en == 1, "R4 broken run", sw_en, 1);
        vcc_ovp_cmp = 1; step(VF);
        vcc_ovp_cmp = 0; step(1);
        chk(sw_en == 0 && fault_cause == 1, "R4 entry", fault_cause, 1);
        step(3 * AR);
        chk(sw_en == 0, "R5 latched", sw_en, 0);
        do_reset();
        chk(sw_en == 1 && fault_cause == 0, "R9 clears latch", sw_en, 1);

        // R7 pin over-temperature needs recovery level
        otp_req = 1; step(1); otp_req = 0;
        chk(fault_cause == 3, "R7 entry", fault_cause, 3);
        step(AR + 20);
        chk(sw_en == 0, "R7 waits level", sw_en, 0);
        otp_rec = 1; step(1);
        chk(sw_en == 1, "R7 exit", sw_en, 1);
        otp_rec = 0;

        // R8 junction over-temperature clears on its own flag
        tsd_req = 1; step(1); tsd_req = 0;
        chk(sw_en == 0 && fault_cause == 2, "R8 entry", fault_cause, 2);
        step(3);
        tsd_clear = 1; step(1); tsd_clear = 0;
        chk(sw_en == 1, "R8 exit", sw_en, 1);

        // R6 held output over-voltage
        ovp_req = 1; step(1);
        chk(fault_cause == 4, "R6 ovp entry", fault_cause, 4);
        step(AR + 5);
        chk(sw_en == 0, "R6 held ovp", sw_en, 0);
        ovp_req = 0; step(1);
        chk(sw_en == 1, "R6 ovp release", sw_en, 1);

        // R11 priority, R12 no restart
        otp_rec = 1;
        scp_req = 1; otp_req = 1; step(1);
        scp_req = 0; otp_req = 0;
        chk(fault_cause == 3, "R11 priority", fault_cause, 3);
        step(30);
        ovp_req = 1; step(1); ovp_req = 0;
        chk(fault_cause == 3, "R11 first wins", fault_cause, 3);
        step(AR - 31);
        chk(sw_en == 0, "R12 before expiry", sw_en, 0);
        step(1);
        chk(sw_en == 1, "R12 not restarted", sw_en, 1);
        otp_rec = 0;
        do_reset();

        // random phase checked against the model every cycle
        for (int k = 0; k < 20000; k++) begin
            tsd_req     = ($urandom_range(0, 299) == 0);
            otp_req     = ($urandom_range(0, 299) == 0);
            ovp_req     = ($urandom_range(0, 299) == 0);
            scp_req     = ($urandom_range(0, 299) == 0);
            tsd_clear   = ($urandom_range(0, 19) == 0);
            otp_rec     = ($urandom_range(0, 3) != 0);
            ilim_term   = ($urandom_range(0, 3) == 0);
            ctrl_reset  = ($urandom_range(0, 499) == 0);
            if (vcc_ovp_cmp) vcc_ovp_cmp = ($urandom_range(0, 9) != 0);
            else vcc_ovp_cmp = ($urandom_range(0, 99) == 0);
            step(1);
        end
        ctrl_reset = 0; tsd_req = 0; otp_req = 0; ovp_req = 0; scp_req = 0;
        ilim_term = 0; vcc_ovp_cmp = 0;
        step(2);
        finish_run();
    end
endmodule